// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block moves a contiguous run of bytes from one address to another. A controller presents a descriptor on its inputs: a configuration word, a byte count, a source address and a destination address. It then pulses `start`. The engine latches the descriptor into live working registers and steps through the region one transaction at a time. Each transaction reads a block of bytes over a valid/ready memory master port, then writes the returned data back out to the destination.

The block size is set by a log2 field in the configuration word. It is capped at the width of the data path. A short final transaction carries any bytes left over. The working registers (`execCfg`, `execBytes`, `execSrc`, `execDst`) are visible at all times, so a supervisor can watch progress or see where a failure stopped the copy. The engine reports the outcome on `done` or `err`.

Configuration fields: read-size log2 in bits 31:28, write-size log2 in bits 27:24, repeat in bit 2. All other bits are stored but have no effect.

Top module: `dma_copy_engine`

## Requirements
- R1: A `start` pulse while idle with `bytesIn` equal to zero has no effect. `busy`, `done`, `err`, the four exec outputs and the memory port all keep their values, and no request is issued.
- R2: When `bytesIn` is non-zero but config bits 31:28 differ from bits 27:24, a start has these effects one cycle later:
  - `err` is set.
  - `done`, `busy` and the exec outputs are left unchanged.
  - No memory request is issued.
- R3: The block size is 2 to the power of the size field, limited to `DATA_BYTES` (64 by default). Every transaction length is the smaller of the block size and the remaining `execBytes`, and is never zero.
- R4: An accepted start (count non-zero, sizes equal, not busy) has these effects one cycle later:
  - `done` and `err` are cleared.
  - `busy` is raised.
  - `execCfg`, `execBytes`, `execSrc` and `execDst` equal `cfgIn`, `bytesIn`, `srcIn` and `dstIn`.
- R5: Each transaction works as follows:
  - It first reads `memReqLen` bytes at `execSrc` (`memReqWrite`=0).
  - It then writes the returned data to `execDst` (`memReqWrite`=1). Byte k of the access travels on data bits 8k+7:8k.
  - After a good write response, both addresses advance by the length and `execBytes` drops by it.
  - The destination ends up holding an exact copy of the source.
- R6: When the count is not a multiple of the block size, the copy ends with one transaction whose length is the remainder.
- R7: When config bit 2 (repeat) is set, successful completion reloads `execBytes`, `execSrc` and `execDst` with the values latched at start.
- R8: After the last good write response, `busy` falls and `done` rises in the same cycle.
- R9: Only one transaction is outstanding at a time. A write is issued only after the read data has returned. No request is presented while idle. A presented request holds its address, direction and length until `memReqReady` is seen.
- R10: A response with `memRspErr` set ends the copy at once: `err` rises, `busy` falls and `done` stays low. The exec outputs keep the values they had before the failing transaction.
- R11: A `start` pulse while `busy` is high is ignored. The copy in progress completes with its original descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start request |
| cfgIn | input | 32 | Descriptor configuration word |
| bytesIn | input | LEN_W | Descriptor byte count |
| srcIn | input | ADDR_W | Descriptor source address |
| dstIn | input | ADDR_W | Descriptor destination address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy completed |
| err | output | 1 | Last start or copy failed |
| execCfg | output | 32 | Live configuration |
| execBytes | output | LEN_W | Live remaining byte count |
| execSrc | output | ADDR_W | Live source address |
| execDst | output | ADDR_W | Live destination address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | ADDR_W | Request byte address |
| memReqLen | output | log2(DATA_BYTES)+1 | Request byte count |
| memReqWdata | output | 8*DATA_BYTES | Write data, byte k on bits 8k+7:8k |
| memRspValid | input | 1 | Response valid |
| memRspErr | input | 1 | Response carries an error |
| memRspRdata | input | 8*DATA_BYTES | Read data, byte k on bits 8k+7:8k |

## Verification
Copies are run with several combinations of count and size field. A count that divides evenly into small blocks shows the per-transaction stepping. A count above the cap with a size field beyond it shows the limit and the short tail, and a mid-sized odd count shows the remainder on its own. The same copy is repeated with a memory that stalls on alternate cycles, to separate handshake timing from the data result. Descriptors with a zero count or unequal size fields, a start during a copy, and an error on the second write each produce a distinct flag and exec-register picture, which tells apart a start that was ignored, a start that was rejected, and a copy that was cut short.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Configuration word field positions
  localparam int CFG_REPEAT_BIT = 2;
  localparam int CFG_WSZ_LSB    = 24;
  localparam int CFG_RSZ_LSB    = 28;
  localparam int CFG_SZ_W       = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch descriptor into exec and origin registers
    logic capture;  // store returned read data
    logic advance;  // step counters by the current transaction length
    logic reload;   // restore exec registers from origin copies
  } dmaStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } dmaState_t;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int DATA_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dmaStrobe_t                  strobe,
  input  logic                        reqWrite,
  input  logic [31:0]                 cfgIn,
  input  logic [LEN_W-1:0]            bytesIn,
  input  logic [ADDR_W-1:0]           srcIn,
  input  logic [ADDR_W-1:0]           dstIn,
  input  logic [DATA_BYTES*8-1:0]     rspData,
  output logic [31:0]                 execCfg,
  output logic [LEN_W-1:0]            execBytes,
  output logic [ADDR_W-1:0]           execSrc,
  output logic [ADDR_W-1:0]           execDst,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic [$clog2(DATA_BYTES):0] txLen,
  output logic [DATA_BYTES*8-1:0]     wrData,
  output logic                        lastTxn,
  output logic                        repeatEn
);

  localparam int DATA_W = DATA_BYTES * 8;
  localparam int SZ_CAP = $clog2(DATA_BYTES);
  localparam int TXN_W  = SZ_CAP + 1;

  logic [LEN_W-1:0]    origBytes;
  logic [ADDR_W-1:0]   origSrc;
  logic [ADDR_W-1:0]   origDst;
  logic [DATA_W-1:0]   dataBuf;
  logic [CFG_SZ_W-1:0] szField;
  logic [CFG_SZ_W-1:0] capLog;
  logic [TXN_W-1:0]    blockSize;

  // Block size from the write-size field (equal to read-size once started)
  always_comb begin
    szField   = execCfg[CFG_WSZ_LSB +: CFG_SZ_W];
    capLog    = (szField > CFG_SZ_W'(SZ_CAP)) ? CFG_SZ_W'(SZ_CAP) : szField;
    blockSize = TXN_W'(1) << capLog;
    txLen     = (execBytes >= LEN_W'(blockSize)) ? blockSize : execBytes[TXN_W-1:0];
    lastTxn   = (execBytes == LEN_W'(txLen));
    repeatEn  = execCfg[CFG_REPEAT_BIT];
    reqAddr   = reqWrite ? execDst : execSrc;
    wrData    = dataBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execCfg   <= '0;
      execBytes <= '0;
      execSrc   <= '0;
      execDst   <= '0;
      origBytes <= '0;
      origSrc   <= '0;
      origDst   <= '0;
    end else if (strobe.load) begin
      execCfg   <= cfgIn;
      execBytes <= bytesIn;
      execSrc   <= srcIn;
      execDst   <= dstIn;
      origBytes <= bytesIn;
      origSrc   <= srcIn;
      origDst   <= dstIn;
    end else if (strobe.advance) begin
      if (strobe.reload) begin
        execBytes <= origBytes;
        execSrc   <= origSrc;
        execDst   <= origDst;
      end else begin
        execBytes <= execBytes - LEN_W'(txLen);
        execSrc   <= execSrc + ADDR_W'(txLen);
        execDst   <= execDst + ADDR_W'(txLen);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBuf <= '0;
    end else if (strobe.capture) begin
      dataBuf <= rspData;
    end
  end

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [LEN_W-1:0]    bytesIn,
  input  logic [CFG_SZ_W-1:0] rdSzIn,
  input  logic [CFG_SZ_W-1:0] wrSzIn,
  input  logic                lastTxn,
  input  logic                repeatEn,
  input  logic                memReqReady,
  input  logic                memRspValid,
  input  logic                memRspErr,
  output dmaStrobe_t          strobe,
  output logic                memReqValid,
  output logic                memReqWrite,
  output logic                busy,
  output logic                done,
  output logic                err
);

  dmaState_t state, nextState;
  logic bytesZero;
  logic sizeMismatch;
  logic startIdle;
  logic rspFail;
  logic finishOk;

  always_comb begin
    bytesZero    = (bytesIn == '0);
    sizeMismatch = (rdSzIn != wrSzIn);
    startIdle    = start && (state == ST_IDLE) && !bytesZero;
    rspFail      = memRspValid && memRspErr &&
                   (state == ST_RD_WAIT || state == ST_WR_WAIT);
    finishOk     = (state == ST_WR_WAIT) && memRspValid && !memRspErr && lastTxn;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startIdle && !sizeMismatch) begin
          strobe.load = 1'b1;
          nextState   = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        if (memReqReady) nextState = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            nextState = ST_IDLE;
          end else begin
            strobe.capture = 1'b1;
            nextState      = ST_WR_REQ;
          end
        end
      end
      ST_WR_REQ: begin
        if (memReqReady) nextState = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            nextState = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            strobe.reload  = lastTxn && repeatEn;
            nextState      = lastTxn ? ST_IDLE : ST_RD_REQ;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else if (startIdle) begin
      if (sizeMismatch) begin
        err <= 1'b1;
      end else begin
        done <= 1'b0;
        err  <= 1'b0;
      end
    end else if (rspFail) begin
      err <= 1'b1;
    end else if (finishOk) begin
      done <= 1'b1;
    end
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    memReqValid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    memReqWrite = (state == ST_WR_REQ);
  end

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int DATA_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [31:0]                 cfgIn,
  input  logic [LEN_W-1:0]            bytesIn,
  input  logic [ADDR_W-1:0]           srcIn,
  input  logic [ADDR_W-1:0]           dstIn,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic [31:0]                 execCfg,
  output logic [LEN_W-1:0]            execBytes,
  output logic [ADDR_W-1:0]           execSrc,
  output logic [ADDR_W-1:0]           execDst,
  output logic                        memReqValid,
  input  logic                        memReqReady,
  output logic                        memReqWrite,
  output logic [ADDR_W-1:0]           memReqAddr,
  output logic [$clog2(DATA_BYTES):0] memReqLen,
  output logic [DATA_BYTES*8-1:0]     memReqWdata,
  input  logic                        memRspValid,
  input  logic                        memRspErr,
  input  logic [DATA_BYTES*8-1:0]     memRspRdata
);

  dmaStrobe_t strobe;
  logic lastTxn;
  logic repeatEn;

  dma_control #(.LEN_W(LEN_W)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .bytesIn     (bytesIn),
    .rdSzIn      (cfgIn[CFG_RSZ_LSB +: CFG_SZ_W]),
    .wrSzIn      (cfgIn[CFG_WSZ_LSB +: CFG_SZ_W]),
    .lastTxn     (lastTxn),
    .repeatEn    (repeatEn),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );

  dma_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .DATA_BYTES (DATA_BYTES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (memReqWrite),
    .cfgIn     (cfgIn),
    .bytesIn   (bytesIn),
    .srcIn     (srcIn),
    .dstIn     (dstIn),
    .rspData   (memRspRdata),
    .execCfg   (execCfg),
    .execBytes (execBytes),
    .execSrc   (execSrc),
    .execDst   (execDst),
    .reqAddr   (memReqAddr),
    .txLen     (memReqLen),
    .wrData    (memReqWdata),
    .lastTxn   (lastTxn),
    .repeatEn  (repeatEn)
  );

endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int DATA_BYTES = 64
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic [31:0]                 cfgIn,
  input logic [LEN_W-1:0]            bytesIn,
  input logic                        busy,
  input logic                        done,
  input logic                        err,
  input logic [LEN_W-1:0]            execBytes,
  input logic                        memReqValid,
  input logic                        memReqReady,
  input logic                        memReqWrite,
  input logic [ADDR_W-1:0]           memReqAddr,
  input logic [$clog2(DATA_BYTES):0] memReqLen,
  input logic                        memRspValid
);

  logic outstanding;
  logic readDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      readDone    <= 1'b0;
    end else begin
      if (memReqValid && memReqReady) outstanding <= 1'b1;
      else if (memRspValid)           outstanding <= 1'b0;
      if (memReqValid && memReqReady) readDone <= !memReqWrite;
    end
  end

  AST_ZERO_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && bytesIn == '0 |=> !busy && $stable(done) && $stable(err)); // R1

  AST_SIZE_MISMATCH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && bytesIn != '0 && cfgIn[31:28] != cfgIn[27:24]
    |=> err && !busy && $stable(done)); // R2

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqLen != '0 && int'(memReqLen) <= DATA_BYTES); // R3

  AST_BUSY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done && !err); // R4

  AST_BYTES_NONINCREASING: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> execBytes <= $past(execBytes)); // R5

  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done != err); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding); // R9

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> readDone); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)
    && $stable(memReqWrite) && $stable(memReqLen)); // R9

endmodule

bind dma_copy_engine dma_copy_engine_chk #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .DATA_BYTES (DATA_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .cfgIn       (cfgIn),
  .bytesIn     (bytesIn),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .execBytes   (execBytes),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memReqLen   (memReqLen),
  .memRspValid (memRspValid)
);

// File: tb/dma_copy_engine_bench.sv
module dma_copy_engine_bench;

  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 32;
  localparam int DATA_BYTES = 64;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int TXN_W      = $clog2(DATA_BYTES) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] cfgIn = '0;
  logic [LEN_W-1:0] bytesIn = '0;
  logic [ADDR_W-1:0] srcIn = '0;
  logic [ADDR_W-1:0] dstIn = '0;
  logic busy, done, err;
  logic [31:0] execCfg;
  logic [LEN_W-1:0] execBytes;
  logic [ADDR_W-1:0] execSrc, execDst;
  logic memReqValid, memReqWrite;
  logic memReqReady = 1'b1;
  logic [ADDR_W-1:0] memReqAddr;
  logic [TXN_W-1:0] memReqLen;
  logic [DATA_W-1:0] memReqWdata;
  logic memRspValid = 1'b0;
  logic memRspErr = 1'b0;
  logic [DATA_W-1:0] memRspRdata = '0;

  always #5 clk = ~clk;

  dma_copy_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) u_dma_copy_engine (
    .clk(clk), .rstN(rstN), .start(start), .cfgIn(cfgIn), .bytesIn(bytesIn),
    .srcIn(srcIn), .dstIn(dstIn), .busy(busy), .done(done), .err(err),
    .execCfg(execCfg), .execBytes(execBytes), .execSrc(execSrc), .execDst(execDst),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqLen(memReqLen), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .memRspRdata(memRspRdata)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // memory model state
  logic [7:0] mem [0:1023];
  bit stallMode = 0;
  bit errArmed = 0;
  bit errOnWrite = 0;
  logic [ADDR_W-1:0] errAddr = '0;
  bit pendValid = 0;
  bit pendWrite = 0;
  logic [ADDR_W-1:0] pendAddr;
  int pendLen;
  logic [DATA_W-1:0] pendData;
  int reqCount = 0;
  int lenLog [0:255];
  bit kindLog [0:255];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      memReqReady = stallMode ? ~memReqReady : 1'b1;
      if (pendValid) begin
        pendValid = 0;
        memRspValid = 1'b1;
        if (errArmed && pendWrite == errOnWrite && pendAddr == errAddr) begin
          memRspErr = 1'b1;
        end else if (pendWrite) begin
          for (int i = 0; i < pendLen; i++) mem[(pendAddr + i) % 1024] = pendData[8*i +: 8];
        end else begin
          memRspRdata = '0;
          for (int i = 0; i < pendLen; i++) memRspRdata[8*i +: 8] = mem[(pendAddr + i) % 1024];
        end
      end else if (memReqValid && memReqReady) begin
        pendValid = 1;
        pendWrite = memReqWrite;
        pendAddr  = memReqAddr;
        pendLen   = int'(memReqLen);
        pendData  = memReqWdata;
        if (reqCount < 256) begin
          lenLog[reqCount]  = pendLen;
          kindLog[reqCount] = memReqWrite;
        end
        reqCount++;
      end
    end
  end

  function automatic logic [31:0] mkCfg(int rsz, int wsz, bit rep);
    return {4'(rsz), 4'(wsz), 21'b0, rep, 2'b0};
  endfunction

  task automatic fillRegion(int src, int dst, int n, int seed);
    for (int i = 0; i < n; i++) begin
      mem[(src + i) % 1024] = 8'((seed * 7 + i * 13 + 1) & 8'hff);
      mem[(dst + i) % 1024] = 8'hee;
    end
  endtask

  task automatic pulseStart(logic [31:0] cfg, int n, int src, int dst);
    @(negedge clk);
    cfgIn = cfg; bytesIn = LEN_W'(n); srcIn = ADDR_W'(src); dstIn = ADDR_W'(dst);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int cnt = 0;
    while (busy && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    if (busy) check(req, 64'(busy), 64'd0, "copy did not finish");
    repeat (2) @(negedge clk);
  endtask

  task automatic checkCopy(string req, int src, int dst, int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[(dst + i) % 1024] !== mem[(src + i) % 1024]) bad++;
    check(req, 64'(bad), 64'd0, "mismatched destination bytes");
  endtask

  task automatic checkLens(string req, int n, int szField);
    int sz = 1 << ((szField > 6) ? 6 : szField);
    int rem = n;
    int idx = 0;
    int bad = 0;
    while (rem > 0) begin
      int l = (rem >= sz) ? sz : rem;
      if (lenLog[idx] != l || kindLog[idx] != 0) bad++;
      if (lenLog[idx+1] != l || kindLog[idx+1] != 1) bad++;
      rem -= l;
      idx += 2;
    end
    check(req, 64'(reqCount), 64'(idx), "request count");
    check(req, 64'(bad), 64'd0, "transaction length/order errors");
  endtask

  task automatic runCopy(string req, logic [31:0] cfg, int n, int src, int dst);
    fillRegion(src, dst, n, n);
    reqCount = 0;
    pulseStart(cfg, n, src, dst);
    waitIdle(req);
  endtask

  task automatic testReset();
    check("R8", 64'(busy), 64'd0, "busy after reset");
    check("R4", 64'({done, err}), 64'd0, "flags after reset");
    check("R9", 64'(memReqValid), 64'd0, "request after reset");
    check("R4", 64'(execBytes), 64'd0, "exec bytes after reset");
  endtask

  task automatic testEvenBlocks();
    runCopy("R5", mkCfg(2, 2, 0), 16, 100, 300);
    checkCopy("R5", 100, 300, 16);
    checkLens("R5", 16, 2);
    check("R5", 64'(execSrc), 64'd116, "exec source advanced");
    check("R5", 64'(execDst), 64'd316, "exec dest advanced");
    check("R8", 64'({busy, done, err}), 64'b010, "busy/done/err at end");
    check("R5", 64'(execBytes), 64'd0, "exec bytes at end");
  endtask

  task automatic testCapped();
    runCopy("R3", mkCfg(9, 9, 0), 70, 0, 500);
    checkCopy("R3", 0, 500, 70);
    checkLens("R3", 70, 9);
    check("R6", 64'(lenLog[2]), 64'd6, "remainder length");
  endtask

  task automatic testRemainder();
    runCopy("R6", mkCfg(3, 3, 0), 13, 200, 400);
    checkCopy("R6", 200, 400, 13);
    checkLens("R6", 13, 3);
    check("R6", 64'(execDst), 64'd413, "exec dest after remainder");
  endtask

  task automatic testZero();
    logic [LEN_W-1:0] b0 = execBytes;
    logic [ADDR_W-1:0] s0 = execSrc;
    logic [31:0] c0 = execCfg;
    reqCount = 0;
    pulseStart(mkCfg(1, 4, 1), 0, 8, 8);
    repeat (4) @(negedge clk);
    check("R1", 64'({busy, done, err}), 64'b010, "flags after zero start");
    check("R1", 64'(execBytes), 64'(b0), "exec bytes after zero start");
    check("R1", 64'(execSrc), 64'(s0), "exec source after zero start");
    check("R1", 64'(execCfg), 64'(c0), "exec config after zero start");
    check("R1", 64'(reqCount), 64'd0, "requests after zero start");
  endtask

  task automatic testMismatch();
    logic [LEN_W-1:0] b0 = execBytes;
    logic [ADDR_W-1:0] d0 = execDst;
    reqCount = 0;
    pulseStart(mkCfg(3, 2, 0), 8, 600, 700);
    check("R2", 64'({busy, done, err}), 64'b011, "flags after size mismatch");
    repeat (4) @(negedge clk);
    check("R2", 64'(execBytes), 64'(b0), "exec bytes after mismatch");
    check("R2", 64'(execDst), 64'(d0), "exec dest after mismatch");
    check("R2", 64'(reqCount), 64'd0, "requests after mismatch");
  endtask

  task automatic testClearOnStart();
    fillRegion(600, 700, 8, 3);
    reqCount = 0;
    pulseStart(mkCfg(1, 1, 0), 8, 600, 700);
    check("R4", 64'({busy, done, err}), 64'b100, "flags right after accepted start");
    check("R4", 64'(execBytes), 64'd8, "exec bytes loaded");
    check("R4", 64'(execSrc), 64'd600, "exec source loaded");
    check("R4", 64'(execCfg), 64'(mkCfg(1, 1, 0)), "exec config loaded");
    waitIdle("R4");
    checkCopy("R4", 600, 700, 8);
  endtask

  task automatic testRepeat();
    runCopy("R7", mkCfg(0, 0, 1), 10, 40, 800);
    checkCopy("R7", 40, 800, 10);
    checkLens("R7", 10, 0);
    check("R7", 64'(execBytes), 64'd10, "exec bytes reloaded");
    check("R7", 64'(execSrc), 64'd40, "exec source reloaded");
    check("R7", 64'(execDst), 64'd800, "exec dest reloaded");
    check("R8", 64'({busy, done, err}), 64'b010, "flags after repeat copy");
  endtask

  task automatic testBusyIgnore();
    fillRegion(120, 900, 32, 5);
    reqCount = 0;
    pulseStart(mkCfg(2, 2, 0), 32, 120, 900);
    repeat (3) @(negedge clk);
    pulseStart(mkCfg(0, 0, 1), 5, 10, 20);
    waitIdle("R11");
    check("R11", 64'(execSrc), 64'd152, "exec source of first copy");
    check("R11", 64'(execCfg), 64'(mkCfg(2, 2, 0)), "exec config of first copy");
    check("R11", 64'(reqCount), 64'd16, "requests of first copy only");
    checkCopy("R11", 120, 900, 32);
  endtask

  task automatic testErrResp();
    errArmed = 1; errOnWrite = 1; errAddr = ADDR_W'(258);
    fillRegion(330, 250, 24, 9);
    reqCount = 0;
    pulseStart(mkCfg(3, 3, 0), 24, 330, 250);
    waitIdle("R10");
    errArmed = 0;
    check("R10", 64'({busy, done, err}), 64'b001, "flags after error response");
    check("R10", 64'(execBytes), 64'd16, "exec bytes at failing transaction");
    check("R10", 64'(execSrc), 64'd338, "exec source at failing transaction");
    check("R10", 64'(execDst), 64'd258, "exec dest at failing transaction");
    check("R10", 64'(reqCount), 64'd4, "requests before stop");
  endtask

  task automatic testStall();
    stallMode = 1;
    runCopy("R9", mkCfg(4, 4, 0), 40, 140, 440);
    stallMode = 0;
    checkCopy("R9", 140, 440, 40);
    checkLens("R9", 40, 4);
    check("R8", 64'({busy, done, err}), 64'b010, "flags after stalled copy");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEvenBlocks();
    testCapped();
    testRemainder();
    testZero();
    testMismatch();
    testClearOnStart();
    testRepeat();
    testBusyIgnore();
    testErrResp();
    testStall();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule